// File: doc/BRIEF.md
# Burst Initiator with Disconnect Resume

This block is the initiator side of a parallel, multiplexed address/data bus with active-low handshake lines. Local logic starts a burst with a start pulse, a byte address, a dword count and a resume flag. The block requests the bus and waits for the grant. It then drives one address phase and one or more data phases, counting each dword that the target accepts. It advances the dword address by four for every accepted item.

A target may end the burst early by asserting its stop line. The block records whether the item in flight was accepted, which depends on the target's ready line at that edge. It then releases the frame line, and one clock later the ready line, so the bus returns to idle. If the transaction was started with resume enabled and dwords are still left, the block waits a fixed gap and requests the bus again. The new tenure starts at the first dword that was not transferred, and a different target may claim it. If resume is disabled, the rest is dropped and completion is reported with an abandoned flag. This is the right choice for speculative prefetch reads.

Top module: `burst_resume_init`

## Requirements
- R1: After reset, req_n_o, frame_n_o and irdy_n_o are high, and done_o, abandoned_o, busy_o and addr_phase_o are low.
- R2: A start pulse with a nonzero length seen while idle drives req_n_o low on the next edge. A start pulse seen while busy_o is high has no effect on the address, the length or the resume choice of the burst in progress.
- R3: A start pulse with length zero gives done_o high with abandoned_o low on the next edge, and req_n_o stays high.
- R4: After gnt_n_i is sampled low while requesting, the next edge drives frame_n_o low and req_n_o high. addr_phase_o is then high for one cycle, and ad_addr_o shows the current dword address with bits 1:0 forced to zero.
- R5: While irdy_n_o is low in a data phase, frame_n_o is low if more than one dword remains and high if the current dword is the last one.
- R6: Each edge with irdy_n_o and trdy_n_i both low counts one dword, advances the address by 4 and lowers the remaining count. When the count reaches zero, done_o pulses high for exactly one cycle.
- R7: When stop_n_i is sampled low in a data phase, frame_n_o is high after that edge and irdy_n_o is high one edge later. The item counts as transferred only if trdy_n_i was low at the same edge.
- R8: With resume enabled and dwords left after a disconnect, req_n_o goes low exactly 2 clocks after irdy_n_o returns high. The next address phase carries the address of the first untransferred dword.
- R9: With resume disabled and dwords left after a disconnect, done_o and abandoned_o pulse high on the edge where irdy_n_o returns high, and the bus is not requested again.
- R10: A disconnect that ends with every dword transferred, including a stop that comes with the final item, completes with abandoned_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse from local logic |
| start_addr_i | input | ADDR_W | Byte address of the first dword |
| start_len_i | input | LEN_W | Number of dwords to transfer |
| start_resume_i | input | 1 | 1: resume after disconnect, 0: abandon (prefetch) |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| abandoned_o | output | 1 | Valid with done_o: remaining dwords were dropped |
| req_n_o | output | 1 | Bus request, active low |
| gnt_n_i | input | 1 | Bus grant, active low |
| frame_n_o | output | 1 | Transaction frame, active low |
| irdy_n_o | output | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop request, active low |
| addr_phase_o | output | 1 | High during the address phase |
| ad_addr_o | output | ADDR_W | Dword-aligned address for the address phase |

## Verification
A wrong remaining count shows up as frame_n_o released one data phase early or late, which is visible in the very phase where it happens. It also shows up as a total of accepted dwords different from the requested length. A stale address register is exposed at the resumed address phase, within three clocks of the disconnect plus the grant delay. An off-by-one gap timer moves the falling edge of req_n_o by a clock, and a wrong resume flag turns a second tenure into an abandoned completion, or the reverse. Each of these faults is seen before done_o.

// File: rtl/bri_pkg.sv
`timescale 1ns/1ps
// Shared types for the burst initiator.
// Assumes: nothing; types only.
package bri_pkg;
    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a start pulse
        S_REQ,    // request asserted, waiting for grant
        S_ADDR,   // address phase
        S_DATA,   // data phases
        S_DISC,   // frame released after stop, ready still asserted
        S_GAP     // idle gap before re-requesting
    } seq_state_t;
endpackage

// File: rtl/bri_addr_track.sv
`timescale 1ns/1ps
// Holds the current dword address and the remaining dword count.
// Assumes: load and step are never high together (load only in idle).
module bri_addr_track #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [LEN_W-1:0]  load_len_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [LEN_W-1:0]  left_o
);
    localparam logic [ADDR_W-1:0] DW_BYTES = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(3);

    // Load on start, advance per accepted dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_o <= '0;
            left_o     <= '0;
        end else if (load_i) begin
            cur_addr_o <= load_addr_i & ~LOW_MASK;
            left_o     <= load_len_i;
        end else if (step_i) begin
            cur_addr_o <= cur_addr_o + DW_BYTES;
            left_o     <= left_o - LEN_W'(1);
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (left_o != '0)); // R6

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (left_o == $past(left_o) - LEN_W'(1))); // R6
endmodule

// File: rtl/bri_gap_timer.sv
`timescale 1ns/1ps
// Counts the idle gap between a disconnect and the next bus request.
// Assumes: GAP_CLKS >= 1; start is a single-cycle pulse.
module bri_gap_timer #(
    parameter int GAP_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic running_o,
    output logic expired_o
);
    localparam int CW = (GAP_CLKS < 2) ? 1 : $clog2(GAP_CLKS + 1);

    logic [CW-1:0] cnt_q;

    // Down-counter that stops when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_o <= 1'b0;
            cnt_q     <= '0;
        end else if (start_i) begin
            running_o <= 1'b1;
            cnt_q     <= CW'(GAP_CLKS - 1);
        end else if (running_o) begin
            if (cnt_q == '0) running_o <= 1'b0;
            else             cnt_q     <= cnt_q - CW'(1);
        end
    end

    // Expiry flag for the sequencer.
    always_comb expired_o = running_o && (cnt_q == '0);

    AST_GAP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !running_o); // R8
endmodule

// File: rtl/bri_phase_fsm.sv
`timescale 1ns/1ps
// Bus phase sequencer: request, address, data, disconnect, gap.
// Assumes: left_i/step_o loop through bri_addr_track; outputs registered.
module bri_phase_fsm
    import bri_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] start_len_i,
    input  logic             start_resume_i,
    input  logic             gnt_n_i,
    input  logic             trdy_n_i,
    input  logic             stop_n_i,
    input  logic [LEN_W-1:0] left_i,
    input  logic             gap_expired_i,
    output logic             load_o,
    output logic             step_o,
    output logic             gap_start_o,
    output seq_state_t       state_o,
    output logic             req_n_o,
    output logic             frame_n_o,
    output logic             irdy_n_o,
    output logic             done_o,
    output logic             abandoned_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    seq_state_t       st_q;
    logic             resume_q;
    logic [LEN_W-1:0] left_after;

    // Handshake decodes for the tracker and the gap timer.
    always_comb begin
        step_o      = (st_q == S_DATA) && !trdy_n_i;
        left_after  = left_i - {{(LEN_W-1){1'b0}}, step_o};
        load_o      = (st_q == S_IDLE) && start_i && (start_len_i != '0);
        gap_start_o = (st_q == S_DISC) && (left_i != '0) && resume_q;
        state_o     = st_q;
    end

    // Phase sequencing and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            resume_q    <= 1'b0;
            req_n_o     <= 1'b1;
            frame_n_o   <= 1'b1;
            irdy_n_o    <= 1'b1;
            done_o      <= 1'b0;
            abandoned_o <= 1'b0;
        end else begin
            done_o      <= 1'b0;
            abandoned_o <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (start_i) begin
                        if (start_len_i == '0) begin
                            done_o <= 1'b1;
                        end else begin
                            st_q     <= S_REQ;
                            req_n_o  <= 1'b0;
                            resume_q <= start_resume_i;
                        end
                    end
                end
                S_REQ: begin
                    if (!gnt_n_i) begin
                        st_q      <= S_ADDR;
                        frame_n_o <= 1'b0;
                        req_n_o   <= 1'b1;
                    end
                end
                S_ADDR: begin
                    st_q      <= S_DATA;
                    irdy_n_o  <= 1'b0;
                    frame_n_o <= (left_i == ONE);
                end
                S_DATA: begin
                    if (!stop_n_i) begin
                        st_q      <= S_DISC;
                        frame_n_o <= 1'b1;
                    end else if (step_o) begin
                        if (left_after == '0) begin
                            st_q      <= S_IDLE;
                            irdy_n_o  <= 1'b1;
                            frame_n_o <= 1'b1;
                            done_o    <= 1'b1;
                        end else begin
                            frame_n_o <= (left_after == ONE);
                        end
                    end
                end
                S_DISC: begin
                    irdy_n_o <= 1'b1;
                    if (left_i == '0) begin
                        st_q   <= S_IDLE;
                        done_o <= 1'b1;
                    end else if (resume_q) begin
                        st_q <= S_GAP;
                    end else begin
                        st_q        <= S_IDLE;
                        done_o      <= 1'b1;
                        abandoned_o <= 1'b1;
                    end
                end
                S_GAP: begin
                    if (gap_expired_i) begin
                        st_q    <= S_REQ;
                        req_n_o <= 1'b0;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    AST_IRDY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irdy_n_o) |-> $past(!frame_n_o)); // R4

    AST_STOP_DROPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DATA && !stop_n_i) |=> frame_n_o); // R7

    AST_IRDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DISC) |=> irdy_n_o); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_ABANDON_ONLY_NO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && abandoned_o) |-> !resume_q); // R9
endmodule

// File: rtl/burst_resume_init.sv
`timescale 1ns/1ps
// Top of the burst initiator with optional resume after target disconnect.
// Assumes: grant held by the arbiter until the address phase is seen.
module burst_resume_init
    import bri_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 8,
    parameter int GAP_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  start_len_i,
    input  logic              start_resume_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              abandoned_o,
    output logic              req_n_o,
    input  logic              gnt_n_i,
    output logic              frame_n_o,
    output logic              irdy_n_o,
    input  logic              trdy_n_i,
    input  logic              stop_n_i,
    output logic              addr_phase_o,
    output logic [ADDR_W-1:0] ad_addr_o
);
    logic             load, step, gap_start, gap_run, gap_exp;
    logic [LEN_W-1:0] left;
    seq_state_t       state;

    bri_addr_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .load_i(load), .load_addr_i(start_addr_i), .load_len_i(start_len_i),
        .step_i(step), .cur_addr_o(ad_addr_o), .left_o(left)
    );

    bri_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .start_i(gap_start), .running_o(gap_run), .expired_o(gap_exp)
    );

    bri_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .start_len_i(start_len_i), .start_resume_i(start_resume_i),
        .gnt_n_i(gnt_n_i), .trdy_n_i(trdy_n_i), .stop_n_i(stop_n_i),
        .left_i(left), .gap_expired_i(gap_exp),
        .load_o(load), .step_o(step), .gap_start_o(gap_start), .state_o(state),
        .req_n_o(req_n_o), .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o),
        .done_o(done_o), .abandoned_o(abandoned_o)
    );

    // Status decodes for local logic and the address phase.
    always_comb begin
        busy_o       = (state != S_IDLE);
        addr_phase_o = (state == S_ADDR);
    end

    AST_GAP_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        gap_run |-> (req_n_o && frame_n_o && irdy_n_o)); // R8

    AST_ADDR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase_o |-> (req_n_o && !frame_n_o)); // R4
endmodule

// File: tb/sim_burst_resume_init.sv
`timescale 1ns/1ps
module sim_burst_resume_init;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [7:0]  start_len = '0;
    logic        start_res = 1'b0;
    logic        busy, done, abandoned, req_n, frame_n, irdy_n, addr_phase;
    logic        gnt_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic [31:0] ad_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    burst_resume_init u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .start_len_i(start_len), .start_resume_i(start_res), .busy_o(busy),
        .done_o(done), .abandoned_o(abandoned), .req_n_o(req_n), .gnt_n_i(gnt_n),
        .frame_n_o(frame_n), .irdy_n_o(irdy_n), .trdy_n_i(trdy_n), .stop_n_i(stop_n),
        .addr_phase_o(addr_phase), .ad_addr_o(ad_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  len;
        logic        res;
        logic [7:0]  stop_at;
        logic        stop_dat;
        logic [3:0]  gdly;
        logic [7:0]  e_xfer;
        logic [1:0]  e_ten;
        logic        e_ab;
        logic [31:0] e_addr2;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 8'd4, 1'b1, 8'd15, 1'b0, 4'd0, 8'd4, 2'd1, 1'b0, 32'h1000},
        '{32'h2000, 8'd5, 1'b1, 8'd2,  1'b1, 4'd1, 8'd5, 2'd2, 1'b0, 32'h200C},
        '{32'h3000, 8'd5, 1'b1, 8'd2,  1'b0, 4'd2, 8'd5, 2'd2, 1'b0, 32'h3008},
        '{32'h4000, 8'd6, 1'b0, 8'd1,  1'b1, 4'd0, 8'd2, 2'd1, 1'b1, 32'h4000},
        '{32'h5000, 8'd3, 1'b0, 8'd0,  1'b0, 4'd3, 8'd0, 2'd1, 1'b1, 32'h5000},
        '{32'h6000, 8'd3, 1'b1, 8'd2,  1'b1, 4'd1, 8'd3, 2'd1, 1'b0, 32'h6000},
        '{32'h7000, 8'd1, 1'b1, 8'd0,  1'b0, 4'd0, 8'd1, 2'd2, 1'b0, 32'h7000},
        '{32'h8000, 8'd4, 1'b0, 8'd3,  1'b1, 4'd2, 8'd4, 2'd1, 1'b0, 32'h8000},
        '{32'hFFF0, 8'd3, 1'b1, 8'd1,  1'b0, 4'd0, 8'd3, 2'd2, 1'b0, 32'hFFF4}
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Runs one transaction with an arbiter and target model; counts outcomes.
    task automatic run_txn(input logic [31:0] a, input int len, input bit res,
                           input int stop_at, input bit stop_dat, input int gdly,
                           input bit extra,
                           output int n_xfer, output int n_ten, output bit ab,
                           output logic [31:0] addr1, output logic [31:0] addr2,
                           output int gap_err, output int frame_err,
                           output bit req_ok, output bit hung);
        int  phase = 0;
        int  gwait = 0;
        int  irdy_hi = -1;
        int  remaining = len;
        bit  stopped = 0;
        bit  seen_done = 0;
        n_xfer = 0; n_ten = 0; ab = 0; addr1 = '0; addr2 = a;
        gap_err = 0; frame_err = 0; req_ok = 0; hung = 0;
        @(negedge clk);
        start = 1'b1; start_addr = a; start_len = 8'(len); start_res = res;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 2000 && !seen_done; cyc++) begin
            if (cyc == 0) req_ok = !req_n;
            start = (extra && cyc == 0);
            if (start) begin start_addr = 32'hA000; start_len = 8'd7; start_res = !res; end
            if (done) begin seen_done = 1; ab = abandoned; end
            if (addr_phase) begin
                n_ten++;
                if (n_ten == 1) addr1 = ad_addr;
                if (n_ten == 2) addr2 = ad_addr;
                if (!req_n || frame_n) frame_err++;
                phase = 0; gnt_n = 1'b1; gwait = 0;
            end
            if (!req_n && irdy_hi >= 0) begin
                if (cyc - irdy_hi != 2) gap_err++;
                irdy_hi = -1;
            end
            if (!req_n && gnt_n && !addr_phase) begin
                if (gwait >= gdly) gnt_n = 1'b0; else gwait++;
            end
            if (!irdy_n && !stopped) begin
                if (frame_n != (remaining == 1)) frame_err++;
                if (n_ten == 1 && phase == stop_at) begin
                    stop_n = 1'b0; trdy_n = !stop_dat; stopped = 1;
                    if (stop_dat) begin n_xfer++; remaining--; end
                end else begin
                    stop_n = 1'b1; trdy_n = 1'b0; n_xfer++; remaining--;
                end
                phase++;
            end else if (!irdy_n && stopped) begin
                stop_n = 1'b0; trdy_n = 1'b1;
            end else begin
                stop_n = 1'b1; trdy_n = 1'b1;
                if (stopped) begin irdy_hi = cyc; stopped = 0; end
            end
            if (!seen_done) @(negedge clk);
        end
        start = 1'b0;
        hung = !seen_done;
    endtask

    initial begin
        int nx, nt, ge, fe;
        bit ab, rq, hg;
        logic [31:0] a1, a2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_n && frame_n && irdy_n, "R1", "bus lines idle", {req_n, frame_n, irdy_n}, 3'b111);
        check(!done && !abandoned && !busy && !addr_phase, "R1", "status low",
              {done, abandoned, busy, addr_phase}, 0);

        for (int i = 0; i < NV; i++) begin
            run_txn(VECS[i].addr, int'(VECS[i].len), VECS[i].res, int'(VECS[i].stop_at),
                    VECS[i].stop_dat, int'(VECS[i].gdly), 1'b0,
                    nx, nt, ab, a1, a2, ge, fe, rq, hg);
            check(!hg, "R6", "completion seen", hg, 0);
            check(rq, "R2", "request after start", rq, 1);
            check(a1 == VECS[i].addr, "R4", "first address", a1, VECS[i].addr);
            check(nx == int'(VECS[i].e_xfer), "R7", "dwords moved", nx, VECS[i].e_xfer);
            check(nt == int'(VECS[i].e_ten), "R8", "bus tenures", nt, VECS[i].e_ten);
            check(a2 == VECS[i].e_addr2, "R8", "resume address", a2, VECS[i].e_addr2);
            check(ge == 0, "R8", "gap errors", ge, 0);
            check(fe == 0, "R5", "frame errors", fe, 0);
            check(ab == VECS[i].e_ab, VECS[i].e_ab ? "R9" : "R10", "abandoned flag", ab, VECS[i].e_ab);
            @(negedge clk);
            check(!done, "R6", "done single cycle", done, 0);
            check(req_n && !busy, "R9", "idle after done", {req_n, busy}, 2'b10);
        end

        // R3: zero length completes without the bus
        @(negedge clk);
        start = 1'b1; start_addr = 32'h100; start_len = 8'd0; start_res = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && !abandoned, "R3", "zero length done", {done, abandoned}, 2'b10);
        check(req_n, "R3", "no request", req_n, 1);

        // R2 / R4: start while busy ignored, unaligned address trimmed
        run_txn(32'h9003, 2, 1'b1, 99, 1'b0, 3, 1'b1, nx, nt, ab, a1, a2, ge, fe, rq, hg);
        check(a1 == 32'h9000, "R4", "aligned address", a1, 32'h9000);
        check(nx == 2 && nt == 1, "R2", "busy start ignored", nx, 2);
        check(!ab && fe == 0, "R5", "clean finish", fe, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule